// File: doc/BRIEF.md
# Page Buffer Main/Spare Access Splitter

This block turns a sequential host byte stream into per-byte addresses for an internal page buffer memory. The buffer has a contiguous main region starting at address 0 and eight separate spare buffers. The host issues one command carrying a starting column, a byte count, a direction, a spare-only flag, a page-size code and a spare-area size. It then streams bytes in, for writes, or takes bytes out, for reads. The block places every byte at the correct physical buffer location.

The spare area of a page is split into one chunk per 512-byte sector. Each chunk sits at the start of its own spare buffer. The number of bytes used in each buffer is the even-rounded share of the spare size. Any bytes left after that even share go to the last buffer in use. A transfer that begins in the main region and runs past the end of the page continues into the spare area with no pause. A transfer that would run past the end of the spare area is shortened, and a status flag reports that it was shortened.

Configurations must keep at least two spare bytes per sector. The used share plus any leftover bytes must fit within one spare buffer of 64 bytes.

Top module: `bsp_splitter`

## Requirements
- R1: A command is taken only in a cycle where `cmd_ready` is high, which is only while idle, and all command fields are captured in that cycle. `cmd_valid` while busy has no effect. Size code 0, 1, 2 and 3 selects a page of 512, 1024, 2048 and 4096 bytes, so 1, 2, 4 and 8 sectors.
- R2: A main-region byte at column c is accessed at buffer address c.
- R3: Each spare buffer holds k = floor(spare_bytes / sectors), rounded down to an even number, used bytes. Spare offset s goes to buffer n = floor(s / k), at address 0x1000 + 64·n + (s − n·k).
- R4: The buffer index n is clamped to sectors − 1, which is at most 7. Spare bytes past the evenly divided part therefore follow on consecutively in the last used buffer.
- R5: A transfer that crosses the page end places its next byte at spare offset 0, with no missing or repeated byte.
- R6: With spare-only set, the column is used directly as the spare offset. Otherwise, a column at or above the page size gives spare offset column − page size.
- R7: On a write, each byte accepted through `wr_valid`/`wr_ready` is written to the buffer in the same cycle, using `mem_we`, `mem_addr` and `mem_wdata`. `mem_we` and `mem_re` are never high together.
- R8: On a read, the block raises `mem_re`, takes `mem_rdata` in the next cycle, and presents the bytes in order on `rd_data`/`rd_valid`. `rd_data` stays stable while `rd_valid` is high and `rd_ready` is low.
- R9: The byte count is cut to the number of bytes left before the end of the spare area. `overflow` is set when a command is cut and cleared when a command is not cut, and it holds its value until the next command. No access is made past the cut count.
- R10: `done` is a one-cycle pulse after the last byte is written or delivered, including a command with zero bytes. The block is ready again in the following cycle.
- R11: After reset, `cmd_ready` is 1, and `done`, `overflow`, `rd_valid`, `mem_we` and `mem_re` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted |
| cmd_col | input | COL_W | Starting column or spare offset |
| cmd_len | input | COL_W | Requested byte count |
| cmd_write | input | 1 | 1 = host to buffer, 0 = buffer to host |
| cmd_spare_only | input | 1 | Column addresses the spare area directly |
| cmd_size_code | input | CODE_W | Page size code |
| cmd_spare_bytes | input | SPR_W | Spare area size in bytes |
| wr_valid | input | 1 | Host write byte valid |
| wr_ready | output | 1 | Block takes a write byte |
| wr_data | input | 8 | Host write byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Host takes the read byte |
| rd_data | output | 8 | Read byte |
| mem_addr | output | ADDR_W | Buffer address |
| mem_we | output | 1 | Buffer write strobe |
| mem_wdata | output | 8 | Buffer write byte |
| mem_re | output | 1 | Buffer read strobe |
| mem_rdata | input | 8 | Buffer read byte, one cycle after `mem_re` |
| done | output | 1 | Transfer complete pulse |
| overflow | output | 1 | Last command was cut at the end of the spare area |

## Verification
The bench builds the block with its default parameters: 512-byte sectors, eight spare buffers with a 64-byte stride at 0x1000, and 13-bit columns. With these values, all four page codes can be exercised, including the 4096-byte page in which the index clamp and the limit of eight buffers coincide. The runs include a seek over several buffers from a spare-only start, a leftover byte landing in the last buffer, a crossing from main into spare, truncation to zero bytes, and host stalls on both streams.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEEK = 2'd1,
        ST_XFER = 2'd2,
        ST_FIN  = 2'd3
    } bsp_state_e;
endpackage

// File: rtl/bsp_geom.sv
// Derives page size, last usable spare buffer and even per-buffer share.
module bsp_geom #(
    parameter int SECT_LOG2 = 9,
    parameter int CODE_W    = 2,
    parameter int SPR_W     = 9,
    parameter int COL_W     = 13,
    parameter int NBUF      = 8,
    localparam int IDX_W    = $clog2(NBUF)
) (
    input  logic [CODE_W-1:0] size_code,
    input  logic [SPR_W-1:0]  spare_bytes,
    output logic [COL_W-1:0]  page_bytes,
    output logic [IDX_W-1:0]  last_buf,
    output logic [SPR_W-1:0]  per_buf
);
    logic [31:0] nsec_m1;

    always_comb begin
        nsec_m1    = (32'd1 << size_code) - 32'd1;
        page_bytes = COL_W'(1) << (32'(SECT_LOG2) + 32'(size_code));
        last_buf   = (nsec_m1 > 32'(NBUF - 1)) ? IDX_W'(NBUF - 1) : IDX_W'(nsec_m1);
        per_buf    = (spare_bytes >> size_code) & ~SPR_W'(1);
    end
endmodule

// File: rtl/bsp_addr.sv
// Maps the current position (main column or spare buffer/offset) to a buffer address.
module bsp_addr #(
    parameter int COL_W        = 13,
    parameter int IDX_W        = 3,
    parameter int ADDR_W       = 13,
    parameter int SPARE_BASE   = 4096,
    parameter int SPARE_STRIDE = 64,
    localparam int STRIDE_LOG2 = $clog2(SPARE_STRIDE)
) (
    input  logic              in_spare,
    input  logic [COL_W-1:0]  pos,
    input  logic [IDX_W-1:0]  buf_idx,
    input  logic [COL_W-1:0]  buf_off,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] spare_addr;

    always_comb begin
        spare_addr = ADDR_W'(SPARE_BASE) + (ADDR_W'(buf_idx) << STRIDE_LOG2) + ADDR_W'(buf_off);
        addr       = in_spare ? spare_addr : ADDR_W'(pos);
    end
endmodule

// File: rtl/bsp_splitter.sv
module bsp_splitter
    import bsp_pkg::*;
#(
    parameter int SECT_LOG2    = 9,
    parameter int CODE_W       = 2,
    parameter int COL_W        = 13,
    parameter int SPR_W        = 9,
    parameter int NBUF         = 8,
    parameter int SPARE_BASE   = 4096,
    parameter int SPARE_STRIDE = 64,
    parameter int ADDR_W       = 13,
    localparam int IDX_W       = $clog2(NBUF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [COL_W-1:0]  cmd_len,
    input  logic              cmd_write,
    input  logic              cmd_spare_only,
    input  logic [CODE_W-1:0] cmd_size_code,
    input  logic [SPR_W-1:0]  cmd_spare_bytes,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata,
    output logic              done,
    output logic              overflow
);
    typedef struct packed {
        bsp_state_e        st;
        logic              wr;
        logic              in_spare;
        logic [COL_W-1:0]  pos;
        logic [IDX_W-1:0]  bidx;
        logic [COL_W-1:0]  boff;
        logic [COL_W-1:0]  rem;
        logic              pend;
        logic              ovld;
        logic [7:0]        odata;
        logic              ovf;
        logic [CODE_W-1:0] code;
        logic [SPR_W-1:0]  spare;
    } regs_t;

    regs_t r_q, r_d;

    // Geometry of the running transfer
    logic [COL_W-1:0] page_q;
    logic [IDX_W-1:0] last_q;
    logic [SPR_W-1:0] per_q;

    bsp_geom #(
        .SECT_LOG2(SECT_LOG2), .CODE_W(CODE_W), .SPR_W(SPR_W),
        .COL_W(COL_W), .NBUF(NBUF)
    ) u_geom (
        .size_code  (r_q.code),
        .spare_bytes(r_q.spare),
        .page_bytes (page_q),
        .last_buf   (last_q),
        .per_buf    (per_q)
    );

    bsp_addr #(
        .COL_W(COL_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
        .SPARE_BASE(SPARE_BASE), .SPARE_STRIDE(SPARE_STRIDE)
    ) u_addr (
        .in_spare(r_q.in_spare),
        .pos     (r_q.pos),
        .buf_idx (r_q.bidx),
        .buf_off (r_q.boff),
        .addr    (mem_addr)
    );

    // Command decode: start region, spare offset and available length
    logic [COL_W-1:0] c_page, c_off, c_spare, c_avail;
    logic             c_spare_path, c_trunc;

    always_comb begin
        c_page       = COL_W'(1) << (32'(SECT_LOG2) + 32'(cmd_size_code));
        c_spare      = COL_W'(cmd_spare_bytes);
        c_spare_path = cmd_spare_only || (cmd_col >= c_page);
        c_off        = cmd_spare_only ? cmd_col : (cmd_col - c_page);
        if (c_spare_path)
            c_avail = (c_off >= c_spare) ? '0 : (c_spare - c_off);
        else
            c_avail = c_page - cmd_col + c_spare;
        c_trunc = cmd_len > c_avail;
    end

    // Port-side handshakes
    assign cmd_ready = (r_q.st == ST_IDLE);
    assign wr_ready  = (r_q.st == ST_XFER) && r_q.wr && (r_q.rem != '0);
    assign mem_we    = wr_valid && wr_ready;
    assign mem_wdata = wr_data;
    assign mem_re    = (r_q.st == ST_XFER) && !r_q.wr && (r_q.rem != '0) && !r_q.pend
                       && (!r_q.ovld || rd_ready);
    assign rd_valid  = r_q.ovld;
    assign rd_data   = r_q.odata;
    assign done      = (r_q.st == ST_FIN);
    assign overflow  = r_q.ovf;

    always_comb begin
        r_d      = r_q;
        r_d.pend = mem_re;
        if (r_q.pend) begin
            r_d.odata = mem_rdata;
            r_d.ovld  = 1'b1;
        end else if (r_q.ovld && rd_ready) begin
            r_d.ovld = 1'b0;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    r_d.code     = cmd_size_code;
                    r_d.spare    = cmd_spare_bytes;
                    r_d.wr       = cmd_write;
                    r_d.ovf      = c_trunc;
                    r_d.rem      = c_trunc ? c_avail : cmd_len;
                    r_d.in_spare = c_spare_path;
                    r_d.pos      = cmd_col;
                    r_d.bidx     = '0;
                    r_d.boff     = c_spare_path ? c_off : '0;
                    r_d.st       = c_spare_path ? ST_SEEK : ST_XFER;
                end
            end
            ST_SEEK: begin
                // one buffer per cycle: subtract the share until it fits
                if ((r_q.bidx < last_q) && (r_q.boff >= COL_W'(per_q))) begin
                    r_d.boff = r_q.boff - COL_W'(per_q);
                    r_d.bidx = r_q.bidx + IDX_W'(1);
                end else begin
                    r_d.st = ST_XFER;
                end
            end
            ST_XFER: begin
                if (mem_we || mem_re) begin
                    r_d.rem = r_q.rem - COL_W'(1);
                    if (!r_q.in_spare) begin
                        if ((r_q.pos + COL_W'(1)) == page_q) begin
                            r_d.in_spare = 1'b1;
                            r_d.bidx     = '0;
                            r_d.boff     = '0;
                        end else begin
                            r_d.pos = r_q.pos + COL_W'(1);
                        end
                    end else if ((r_q.bidx < last_q) &&
                                 ((r_q.boff + COL_W'(1)) >= COL_W'(per_q))) begin
                        r_d.bidx = r_q.bidx + IDX_W'(1);
                        r_d.boff = '0;
                    end else begin
                        r_d.boff = r_q.boff + COL_W'(1);
                    end
                end else if ((r_q.rem == '0) && !r_q.pend && !r_q.ovld) begin
                    r_d.st = ST_FIN;
                end
            end
            ST_FIN:  r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Assertions
    AST_MAIN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && !r_q.in_spare) |-> (mem_addr < ADDR_W'(page_q))); // R2
    AST_SPARE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && r_q.in_spare) |->
        ((mem_addr >= ADDR_W'(SPARE_BASE)) &&
         (mem_addr < ADDR_W'(SPARE_BASE + NBUF * SPARE_STRIDE)))); // R3
    AST_SHARE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_XFER) && r_q.in_spare && (r_q.bidx != last_q)) |->
        (r_q.boff < COL_W'(per_q))); // R4
    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R7
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R8
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_XFER) && (r_q.rem == '0)) |-> (!mem_we && !mem_re)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready)); // R10
endmodule

// File: tb/test_bsp_splitter.sv
module test_bsp_splitter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [12:0] cmd_col = '0;
    logic [12:0] cmd_len = '0;
    logic        cmd_write = 1'b0;
    logic        cmd_spare_only = 1'b0;
    logic [1:0]  cmd_size_code = '0;
    logic [8:0]  cmd_spare_bytes = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  wr_data = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic [7:0]  rd_data;
    logic [12:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic        mem_re;
    logic [7:0]  mem_rdata = '0;
    logic        done;
    logic        overflow;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bsp_splitter i_bsp_splitter (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_col(cmd_col), .cmd_len(cmd_len),
        .cmd_write(cmd_write), .cmd_spare_only(cmd_spare_only),
        .cmd_size_code(cmd_size_code), .cmd_spare_bytes(cmd_spare_bytes),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata),
        .done(done), .overflow(overflow)
    );

    // Buffer model: content is a fixed function of the address
    function automatic logic [7:0] pat(int a);
        return 8'((a * 13) + (a >> 8) + 5);
    endfunction

    always @(posedge clk) if (mem_re) mem_rdata <= pat(int'(mem_addr));

    function automatic int exp_addr(bit so, int col, int k, int code, int spare);
        int page, nsec, per, lg, off, idx;
        page = 512 << code;
        nsec = 1 << code;
        per  = (spare / nsec) & ~1;
        lg   = col + k;
        if (!so && lg < page) return lg;
        off = so ? lg : lg - page;
        idx = off / per;
        if (idx > nsec - 1) idx = nsec - 1;
        return 4096 + idx * 64 + off - idx * per;
    endfunction

    function automatic string tag_of(bit so, int col, int k, int code, int spare);
        int page, nsec, per, off;
        page = 512 << code;
        nsec = 1 << code;
        per  = (spare / nsec) & ~1;
        if (!so && col + k < page) return "R2";
        off = so ? col + k : col + k - page;
        if (off / per > nsec - 1) return "R4";
        if (!so && col < page) return "R5";
        if (so || col >= page) return "R6";
        return "R3";
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run(bit wr, bit so, int col, int len, int code, int spare, bit stall, bit noise);
        int page, off, avail, eff, kacc, kiss, krd, ndone, guard, a;
        bit sp, expov, prv, prr;
        logic [7:0] pd;
        page  = 512 << code;
        sp    = so || (col >= page);
        off   = so ? col : col - page;
        avail = sp ? ((off >= spare) ? 0 : spare - off) : page - col + spare;
        eff   = (len > avail) ? avail : len;
        expov = len > avail;

        #1;
        check(cmd_ready === 1'b1, "R1", "cmd_ready idle before command", int'(cmd_ready), 1);
        cmd_valid = 1'b1;
        cmd_col = 13'(col); cmd_len = 13'(len); cmd_write = wr; cmd_spare_only = so;
        cmd_size_code = 2'(code); cmd_spare_bytes = 9'(spare);
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;

        kacc = 0; kiss = 0; krd = 0; ndone = 0; guard = 0;
        prv = 1'b0; prr = 1'b0; pd = '0;
        while (ndone == 0 && guard < 3000) begin
            wr_valid = wr && (kacc < eff) && !(stall && (cyc % 3 == 1));
            wr_data  = 8'((col + kacc) * 7 + 3);
            rd_ready = !(stall && (cyc % 4 == 2));
            cmd_valid = noise && !cmd_ready;
            if (noise) begin
                cmd_col = 13'd3; cmd_len = 13'd9; cmd_write = !wr; cmd_size_code = 2'd3;
            end
            #1;
            if (prv && !prr)
                check(rd_valid === 1'b1 && rd_data === pd, "R8", "stalled read byte held",
                      int'(rd_data), int'(pd));
            if (cmd_valid)
                check(cmd_ready === 1'b0, "R1", "command refused while busy", int'(cmd_ready), 0);
            check(!(mem_we && mem_re), "R7", "write and read together", int'(mem_re), 0);
            if (mem_we) begin
                if (kacc >= eff) check(1'b0, "R9", "write beyond cut length", kacc, eff);
                else begin
                    a = exp_addr(so, col, kacc, code, spare);
                    check(int'(mem_addr) == a, tag_of(so, col, kacc, code, spare),
                          "write address", int'(mem_addr), a);
                    check(mem_wdata == wr_data, "R7", "write data", int'(mem_wdata), int'(wr_data));
                end
                kacc++;
            end
            if (mem_re) begin
                if (kiss >= eff) check(1'b0, "R9", "read beyond cut length", kiss, eff);
                else begin
                    a = exp_addr(so, col, kiss, code, spare);
                    check(int'(mem_addr) == a, tag_of(so, col, kiss, code, spare),
                          "read address", int'(mem_addr), a);
                end
                kiss++;
            end
            if (rd_valid && rd_ready) begin
                a = exp_addr(so, col, krd, code, spare);
                check(rd_data === pat(a), "R8", "read byte", int'(rd_data), int'(pat(a)));
                krd++;
            end
            if (done) ndone++;
            prv = rd_valid; prr = rd_ready; pd = rd_data;
            @(posedge clk); @(negedge clk);
            guard++;
        end
        wr_valid = 1'b0; cmd_valid = 1'b0; rd_ready = 1'b1;
        #1;
        check(ndone == 1, "R10", "done pulse seen", ndone, 1);
        check((wr ? kacc : krd) == eff, "R9", "bytes moved", wr ? kacc : krd, eff);
        check(overflow === expov, "R9", "overflow flag", int'(overflow), int'(expov));
        check(done === 1'b0, "R10", "done lasts one cycle", int'(done), 0);
        check(cmd_ready === 1'b1, "R10", "ready after done", int'(cmd_ready), 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        check(cmd_ready === 1'b1, "R11", "cmd_ready after reset", int'(cmd_ready), 1);
        check(done === 1'b0 && overflow === 1'b0, "R11", "done/overflow after reset",
              int'(done) + int'(overflow), 0);
        check(!mem_we && !mem_re && !rd_valid, "R11", "no activity after reset",
              int'(mem_we) + int'(mem_re) + int'(rd_valid), 0);
        @(negedge clk);

        // R4, R6: spare-only read, 4096 page, seek across buffers, leftover into buffer 7
        run(1'b0, 1'b1, 150, 68, 3, 218, 1'b1, 1'b0);
        // R4, R5, R9: read crossing into spare, odd spare leftover, truncated
        run(1'b0, 1'b0, 1020, 100, 1, 33, 1'b0, 1'b0);
        // R9: nothing available at all
        run(1'b0, 1'b1, 40, 3, 0, 16, 1'b0, 1'b0);
        // R10, R9: zero-length command clears overflow
        run(1'b0, 1'b0, 0, 0, 0, 16, 1'b0, 1'b0);
        // R2, R7: main writes with host stalls
        run(1'b1, 1'b0, 10, 5, 0, 16, 1'b1, 1'b0);
        // R5, R1: write crossing page end into buffers 0 and 1, command noise while busy
        run(1'b1, 1'b0, 2040, 30, 2, 64, 1'b1, 1'b1);
        // R6: column above page without spare-only flag
        run(1'b1, 1'b0, 520, 4, 0, 16, 1'b0, 1'b0);
        // R3, R9: spare-only write from buffer 2 into 3, cut at spare end
        run(1'b1, 1'b1, 45, 30, 2, 64, 1'b0, 1'b1);
        // R2, R8: plain main read with stalls on a 2048 page
        run(1'b0, 1'b0, 700, 9, 2, 64, 1'b1, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule